// File: doc/BRIEF.md
# Protection configuration register file

This block stores the settings a memory-protection unit works from: one configuration byte per protection entry, one address register per entry, and a security-mode register. Software reaches them through a single register port made of a write strobe, a register index and a write data word, with a registered read-back word. The contents go out in parallel to the region decoder and the access checker, which are separate blocks.

The block enforces the protection write rules itself, so each byte of a write is either stored or dropped on its own. A configuration byte is judged by its entry's lock bit and by two security-mode bits. One of them is a bypass that reopens locked entries. The other is a lockdown that replaces the lock test with a rule on the value being written. An address write is also refused when the following entry is locked in top-of-range mode, because that entry uses this address as its lower bound. The lockdown and whitelist-only mode bits can be set but never cleared by a write. The bypass bit cannot be turned on once any entry is locked. A one-cycle error pulse reports every write that was refused in whole or in part.

The enhanced security rules are on by default and can be left out through a parameter. All registers reset to zero.

Top module: `prot_cfg_regfile`

## Requirements
- R1: After synchronous reset every configuration byte, address register, mode bit, read-back word and the error pulse are zero.
- R2: Configuration byte layout: bit 0 read, bit 1 write, bit 2 execute, bits 4:3 match mode (0 off, 1 top-of-range, 2 naturally aligned 4-byte, 3 naturally aligned power of two), bit 7 lock. Index n (0..3) is a configuration word. Its byte i (bits 8i+7:8i) belongs to entry 4n+i, and reads return the four bytes in the same positions. Entry k appears on cfg_bytes bits 8k+7:8k.
- R3: With bypass and lockdown both clear, a configuration byte whose entry has its lock bit set is dropped. The other bytes of the same word are still judged on their own.
- R4: While the bypass bit is set, every configuration byte write is stored, locked entries included.
- R5: While lockdown is set and bypass is clear, a configuration byte is stored only if it has lock set and execute clear, or lock clear and bits 2:0 not equal to 3'b110. The entry's current lock bit plays no part in this.
- R6: Indices 0x10..0x1F write the address registers of entries 0..15, and addr_regs bits 32k+31:32k hold entry k. An address write is dropped if its own entry is locked, or if entry k+1 is locked with match mode 1 (top-of-range). A locked next entry in any other mode does not block the write. The last entry has no next entry.
- R7: Index 0x20 is the security register: bit 0 lockdown, bit 1 whitelist-only, bit 2 bypass, other bits read zero. Once set, lockdown and whitelist-only cannot be cleared by a write. Bypass can be cleared.
- R8: A write that sets bit 2 of the security register leaves bypass at 0 when bypass is currently clear and any entry has its lock bit set. When bypass is already set, the write keeps it set.
- R9: Writes to any index other than 0x00..0x03, 0x10..0x1F and 0x20 change nothing, and reads of such indices return zero.
- R10: wr_err is high for exactly the one cycle after a write strobe whose write was refused in whole or in part: a dropped configuration byte, a dropped address write, a masked bypass bit, or an unmapped index. It stays low after fully accepted writes.
- R11: csr_rdata is registered. It shows the register selected by csr_idx at the previous clock edge, with its contents from before any write taken at that same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_we | input | 1 | Write strobe for the selected register |
| csr_idx | input | 6 | Register index for write and read-back |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Registered read-back of the selected register |
| cfg_bytes | output | 128 | All entry configuration bytes, entry k at bits 8k+7:8k |
| addr_regs | output | 512 | All entry address registers, entry k at bits 32k+31:32k |
| mode_lockdown | output | 1 | Security mode: lockdown bit |
| mode_whitelist | output | 1 | Security mode: whitelist-only bit |
| mode_bypass | output | 1 | Security mode: lock bypass bit |
| wr_err | output | 1 | One-cycle pulse for a write that was refused in whole or in part |

## Verification
A write and a read-back of the same register fall in the same cycle, because csr_idx selects both the write target and the read-back source at one edge. The bench writes a configuration word and samples csr_rdata right after that edge. It expects the old contents, then expects the new contents one cycle later. The other coincidence is a partial refusal: one word carries bytes that are stored and bytes that are dropped. The bench judges each byte on cfg_bytes against the rule worked out by hand for it, and expects the error pulse for the same write.

// File: rtl/prot_cfg_pkg.sv
package prot_cfg_pkg;

  localparam int CFG_BYTE_W = 8;

  // security register field positions (read-back layout)
  localparam int SEC_LD_BIT = 0;
  localparam int SEC_WL_BIT = 1;
  localparam int SEC_BP_BIT = 2;
  localparam int SEC_FIELD_W = 3;

  typedef enum logic [1:0] {
    AM_OFF   = 2'd0,
    AM_TOR   = 2'd1,
    AM_NA4   = 2'd2,
    AM_NAPOT = 2'd3
  } amatch_e;

  typedef struct packed {
    logic       lock;
    logic [1:0] spare;
    amatch_e    amatch;
    logic       x;
    logic       w;
    logic       r;
  } cfg_byte_t;

  // value rule applied while lockdown is active
  function automatic logic lockdown_allows(cfg_byte_t nv);
    logic [2:0] perm;
    perm = {nv.x, nv.w, nv.r};
    return (nv.lock && !nv.x) || (!nv.lock && (perm != 3'b110));
  endfunction

endpackage

// File: rtl/prot_cfg_entry.sv
module prot_cfg_entry
  import prot_cfg_pkg::*;
#(
  parameter bit ENHANCED = 1'b1
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      wr,
  input  cfg_byte_t wdata,
  input  logic      lockdown,
  input  logic      bypass,
  output cfg_byte_t cfg_q,
  output logic      dropped
);

  logic accept;

  generate
    if (ENHANCED) begin : g_enh
      always_comb begin
        if (bypass)        accept = 1'b1;
        else if (lockdown) accept = lockdown_allows(wdata);
        else               accept = !cfg_q.lock;
      end
    end else begin : g_base
      assign accept = !cfg_q.lock;
    end
  endgenerate

  assign dropped = wr && !accept;

  always_ff @(posedge clk) begin
    if (rst)               cfg_q <= '0;
    else if (wr && accept) cfg_q <= wdata;
  end

  AST_LOCKED_BYTE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!bypass && !lockdown && cfg_q.lock) |=> $stable(cfg_q)); // R3

  AST_LOCKDOWN_NO_WX: assert property (@(posedge clk) disable iff (rst)
    (wr && lockdown && !bypass && !wdata.lock && wdata.x && wdata.w && !wdata.r)
      |=> $stable(cfg_q)); // R5

  AST_BYPASS_STORES: assert property (@(posedge clk) disable iff (rst)
    (ENHANCED && wr && bypass) |=> (cfg_q == $past(wdata))); // R4

endmodule

// File: rtl/prot_addr_entry.sv
module prot_addr_entry #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [ADDR_W-1:0] wdata,
  input  logic              own_lock,
  input  logic              next_tor_lock,
  output logic [ADDR_W-1:0] addr_q,
  output logic              dropped
);

  logic blocked;

  assign blocked = own_lock || next_tor_lock;
  assign dropped = wr && blocked;

  always_ff @(posedge clk) begin
    if (rst)                 addr_q <= '0;
    else if (wr && !blocked) addr_q <= wdata;
  end

  AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (own_lock || next_tor_lock) |=> $stable(addr_q)); // R6

  AST_ADDR_STORES: assert property (@(posedge clk) disable iff (rst)
    (wr && !own_lock && !next_tor_lock) |=> (addr_q == $past(wdata))); // R6

endmodule

// File: rtl/prot_sec_ctrl.sv
module prot_sec_ctrl
  import prot_cfg_pkg::*;
#(
  parameter bit ENHANCED = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr,
  input  logic [SEC_FIELD_W-1:0] wbits,
  input  logic                   any_locked,
  output logic                   lockdown,
  output logic                   whitelist,
  output logic                   bypass,
  output logic                   dropped
);

  generate
    if (ENHANCED) begin : g_sec
      logic bp_allowed;
      assign bp_allowed = bypass || !any_locked;
      assign dropped    = wr && wbits[SEC_BP_BIT] && !bp_allowed;

      always_ff @(posedge clk) begin
        if (rst) begin
          lockdown  <= 1'b0;
          whitelist <= 1'b0;
          bypass    <= 1'b0;
        end else if (wr) begin
          lockdown  <= lockdown  || wbits[SEC_LD_BIT];
          whitelist <= whitelist || wbits[SEC_WL_BIT];
          bypass    <= wbits[SEC_BP_BIT] && bp_allowed;
        end
      end
    end else begin : g_nosec
      assign lockdown  = 1'b0;
      assign whitelist = 1'b0;
      assign bypass    = 1'b0;
      assign dropped   = 1'b0;
    end
  endgenerate

  AST_LOCKDOWN_STICKY: assert property (@(posedge clk) disable iff (rst)
    lockdown |=> lockdown); // R7

  AST_WHITELIST_STICKY: assert property (@(posedge clk) disable iff (rst)
    whitelist |=> whitelist); // R7

  AST_BYPASS_MASKED: assert property (@(posedge clk) disable iff (rst)
    (!bypass && any_locked) |=> !bypass); // R8

endmodule

// File: rtl/prot_cfg_regfile.sv
module prot_cfg_regfile
  import prot_cfg_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int DATA_W      = 32,
  parameter bit ENHANCED    = 1'b1,
  localparam int IDX_W      = $clog2(2 * NUM_ENTRIES + 1)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          csr_we,
  input  logic [IDX_W-1:0]              csr_idx,
  input  logic [DATA_W-1:0]             csr_wdata,
  output logic [DATA_W-1:0]             csr_rdata,
  output logic [NUM_ENTRIES*CFG_BYTE_W-1:0] cfg_bytes,
  output logic [NUM_ENTRIES*DATA_W-1:0] addr_regs,
  output logic                          mode_lockdown,
  output logic                          mode_whitelist,
  output logic                          mode_bypass,
  output logic                          wr_err
);

  localparam int BYTES_PER_CSR = DATA_W / CFG_BYTE_W;
  localparam int NUM_CFG_CSR   = NUM_ENTRIES / BYTES_PER_CSR;
  localparam int ADDR_BASE     = NUM_ENTRIES;
  localparam int SEC_IDX       = 2 * NUM_ENTRIES;

  localparam logic [IDX_W-1:0] CFG_END_I   = IDX_W'(NUM_CFG_CSR);
  localparam logic [IDX_W-1:0] ADDR_BASE_I = IDX_W'(ADDR_BASE);
  localparam logic [IDX_W-1:0] SEC_I       = IDX_W'(SEC_IDX);

  // ---------------- index decode ----------------
  logic idx_cfg, idx_addr, idx_sec, idx_bad;

  assign idx_cfg  = (csr_idx < CFG_END_I);
  assign idx_addr = (csr_idx >= ADDR_BASE_I) && (csr_idx < SEC_I);
  assign idx_sec  = (csr_idx == SEC_I) && ENHANCED;
  assign idx_bad  = !(idx_cfg || idx_addr || idx_sec);

  // ---------------- storage lanes ----------------
  cfg_byte_t         cfg_q  [NUM_ENTRIES];
  logic [DATA_W-1:0] addr_q [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] cfg_drop, addr_drop, next_tor_lock, lock_vec;
  logic any_locked, sec_drop;
  logic sec_ld, sec_wl, sec_bp;

  genvar k;
  generate
    for (k = 0; k < NUM_ENTRIES; k++) begin : g_ent
      localparam int GRP  = k / BYTES_PER_CSR;
      localparam int LANE = k % BYTES_PER_CSR;
      logic wr_cfg, wr_addr;

      assign wr_cfg  = csr_we && idx_cfg && (csr_idx == IDX_W'(GRP));
      assign wr_addr = csr_we && (csr_idx == IDX_W'(ADDR_BASE + k));

      prot_cfg_entry #(.ENHANCED(ENHANCED)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .wr       (wr_cfg),
        .wdata    (cfg_byte_t'(csr_wdata[CFG_BYTE_W*LANE +: CFG_BYTE_W])),
        .lockdown (sec_ld),
        .bypass   (sec_bp),
        .cfg_q    (cfg_q[k]),
        .dropped  (cfg_drop[k])
      );

      if (k + 1 < NUM_ENTRIES) begin : g_next
        assign next_tor_lock[k] = cfg_q[k+1].lock && (cfg_q[k+1].amatch == AM_TOR);
      end else begin : g_last
        assign next_tor_lock[k] = 1'b0;
      end

      prot_addr_entry #(.ADDR_W(DATA_W)) u_addr (
        .clk           (clk),
        .rst           (rst),
        .wr            (wr_addr),
        .wdata         (csr_wdata),
        .own_lock      (cfg_q[k].lock),
        .next_tor_lock (next_tor_lock[k]),
        .addr_q        (addr_q[k]),
        .dropped       (addr_drop[k])
      );

      assign lock_vec[k] = cfg_q[k].lock;
      assign cfg_bytes[CFG_BYTE_W*k +: CFG_BYTE_W] = cfg_q[k];
      assign addr_regs[DATA_W*k +: DATA_W]         = addr_q[k];
    end
  endgenerate

  assign any_locked = |lock_vec;

  prot_sec_ctrl #(.ENHANCED(ENHANCED)) u_sec (
    .clk        (clk),
    .rst        (rst),
    .wr         (csr_we && idx_sec),
    .wbits      (csr_wdata[SEC_FIELD_W-1:0]),
    .any_locked (any_locked),
    .lockdown   (sec_ld),
    .whitelist  (sec_wl),
    .bypass     (sec_bp),
    .dropped    (sec_drop)
  );

  assign mode_lockdown  = sec_ld;
  assign mode_whitelist = sec_wl;
  assign mode_bypass    = sec_bp;

  // ---------------- read-back and error ----------------
  logic [DATA_W-1:0] rd_d;
  logic              err_d;

  always_comb begin
    rd_d = '0;
    for (int g = 0; g < NUM_CFG_CSR; g++) begin
      if (csr_idx == IDX_W'(g)) begin
        for (int b = 0; b < BYTES_PER_CSR; b++) begin
          rd_d[CFG_BYTE_W*b +: CFG_BYTE_W] = cfg_q[g*BYTES_PER_CSR + b];
        end
      end
    end
    for (int e = 0; e < NUM_ENTRIES; e++) begin
      if (csr_idx == IDX_W'(ADDR_BASE + e)) rd_d = addr_q[e];
    end
    if (idx_sec) begin
      rd_d[SEC_LD_BIT] = sec_ld;
      rd_d[SEC_WL_BIT] = sec_wl;
      rd_d[SEC_BP_BIT] = sec_bp;
    end
  end

  assign err_d = (|cfg_drop) || (|addr_drop) || sec_drop || (csr_we && idx_bad);

  always_ff @(posedge clk) begin
    if (rst) begin
      csr_rdata <= '0;
      wr_err    <= 1'b0;
    end else begin
      csr_rdata <= rd_d;
      wr_err    <= err_d;
    end
  end

  AST_ERR_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (rst)
    wr_err |-> $past(csr_we)); // R10

  AST_BAD_IDX_FLAGGED: assert property (@(posedge clk) disable iff (rst)
    (csr_we && idx_bad) |=> wr_err); // R9

  AST_BAD_IDX_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    idx_bad |=> (csr_rdata == '0)); // R9

endmodule

// File: tb/tb_prot_cfg_regfile.sv
`timescale 1ns/1ps
module tb_prot_cfg_regfile;

  localparam int N  = 16;
  localparam int DW = 32;
  localparam int IW = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic csr_we = 1'b0;
  logic [IW-1:0] csr_idx = '0;
  logic [DW-1:0] csr_wdata = '0;
  logic [DW-1:0] csr_rdata;
  logic [N*8-1:0] cfg_bytes;
  logic [N*DW-1:0] addr_regs;
  logic mode_lockdown, mode_whitelist, mode_bypass, wr_err;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic err_seen;
  logic [DW-1:0] rd_at_wr;
  logic [DW-1:0] rv;

  always #2.5 clk = ~clk;

  prot_cfg_regfile dut (
    .clk(clk), .rst(rst), .csr_we(csr_we), .csr_idx(csr_idx),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .cfg_bytes(cfg_bytes),
    .addr_regs(addr_regs), .mode_lockdown(mode_lockdown),
    .mode_whitelist(mode_whitelist), .mode_bypass(mode_bypass), .wr_err(wr_err)
  );

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; csr_we = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [IW-1:0] idx, input logic [DW-1:0] data);
    @(negedge clk);
    csr_we = 1'b1; csr_idx = idx; csr_wdata = data;
    @(negedge clk);
    csr_we = 1'b0;
    err_seen = wr_err;
    rd_at_wr = csr_rdata;
  endtask

  task automatic rd(input logic [IW-1:0] idx, output logic [DW-1:0] data);
    @(negedge clk);
    csr_idx = idx;
    @(negedge clk);
    data = csr_rdata;
  endtask

  function automatic logic [7:0] cfgb(input int k);
    return cfg_bytes[8*k +: 8];
  endfunction

  function automatic logic [DW-1:0] areg(input int k);
    return addr_regs[DW*k +: DW];
  endfunction

  task automatic t_reset();
    do_reset();
    chk("R1 cfg_bytes zero", 64'(|cfg_bytes), 64'd0);
    chk("R1 addr_regs zero", 64'(|addr_regs), 64'd0);
    chk("R1 mode bits zero", {61'd0, mode_lockdown, mode_whitelist, mode_bypass}, 64'd0);
    chk("R1 wr_err zero", 64'(wr_err), 64'd0);
    chk("R1 rdata zero", 64'(csr_rdata), 64'd0);
    rd(6'h20, rv);
    chk("R1 security reads zero", 64'(rv), 64'd0);
  endtask

  task automatic t_pack();
    do_reset();
    wr(6'h00, 32'h1B0A0301);
    chk("R2 entry0 byte", 64'(cfgb(0)), 64'h01);
    chk("R2 entry1 byte", 64'(cfgb(1)), 64'h03);
    chk("R2 entry2 byte", 64'(cfgb(2)), 64'h0A);
    chk("R2 entry3 byte", 64'(cfgb(3)), 64'h1B);
    chk("R10 no error on accepted write", 64'(err_seen), 64'd0);
    rd(6'h00, rv);
    chk("R2 word0 readback", 64'(rv), 64'h1B0A0301);
    wr(6'h03, 32'h44332211);
    chk("R2 entry12 byte", 64'(cfgb(12)), 64'h11);
    chk("R2 entry15 byte", 64'(cfgb(15)), 64'h44);
    rd(6'h03, rv);
    chk("R2 word3 readback", 64'(rv), 64'h44332211);
  endtask

  task automatic t_rd_timing();
    do_reset();
    wr(6'h01, 32'h05060708);
    chk("R11 rdata in write cycle shows old value", 64'(rd_at_wr), 64'd0);
    @(negedge clk);
    chk("R11 rdata one cycle later shows new value", 64'(csr_rdata), 64'h05060708);
  endtask

  task automatic t_lock();
    do_reset();
    wr(6'h00, 32'h00000381);
    wr(6'h00, 32'h00000707);
    chk("R3 locked entry0 unchanged", 64'(cfgb(0)), 64'h81);
    chk("R3 unlocked entry1 written", 64'(cfgb(1)), 64'h07);
    chk("R10 error on partial drop", 64'(err_seen), 64'd1);
    @(negedge clk);
    chk("R10 error pulse lasts one cycle", 64'(wr_err), 64'd0);
  endtask

  task automatic t_addr();
    do_reset();
    wr(6'h10, 32'h00001234);
    chk("R6 address write accepted", 64'(areg(0)), 64'h1234);
    chk("R10 no error on address write", 64'(err_seen), 64'd0);
    wr(6'h00, 32'h00000080);
    wr(6'h10, 32'h00005555);
    chk("R6 own lock blocks address", 64'(areg(0)), 64'h1234);
    chk("R10 error on own-lock address drop", 64'(err_seen), 64'd1);
    wr(6'h00, 32'h00880080);
    wr(6'h11, 32'h0000AAAA);
    chk("R6 next locked top-of-range blocks address", 64'(areg(1)), 64'h0);
    chk("R10 error on next-lock address drop", 64'(err_seen), 64'd1);
    wr(6'h01, 32'h00009000);
    wr(6'h14, 32'h00007777);
    chk("R6 next locked non-TOR does not block", 64'(areg(4)), 64'h7777);
    chk("R10 no error when next lock is not TOR", 64'(err_seen), 64'd0);
    wr(6'h1F, 32'h0000CAFE);
    chk("R6 last entry address accepted", 64'(areg(15)), 64'hCAFE);
    rd(6'h1F, rv);
    chk("R6 last entry address readback", 64'(rv), 64'hCAFE);
  endtask

  task automatic t_range();
    do_reset();
    wr(6'h04, 32'hFFFFFFFF);
    chk("R10 error on unmapped config index", 64'(err_seen), 64'd1);
    chk("R9 unmapped config index writes nothing", 64'(|cfg_bytes), 64'd0);
    rd(6'h04, rv);
    chk("R9 unmapped index 0x04 reads zero", 64'(rv), 64'd0);
    wr(6'h21, 32'hFFFFFFFF);
    chk("R9 index 0x21 error", 64'(err_seen), 64'd1);
    chk("R9 index 0x21 leaves modes", {61'd0, mode_lockdown, mode_whitelist, mode_bypass}, 64'd0);
    chk("R9 index 0x21 leaves addresses", 64'(|addr_regs), 64'd0);
    rd(6'h3F, rv);
    chk("R9 index 0x3F reads zero", 64'(rv), 64'd0);
  endtask

  task automatic t_lockdown();
    do_reset();
    wr(6'h20, 32'hFFFFFFFF);
    chk("R7 all mode bits set", {61'd0, mode_lockdown, mode_whitelist, mode_bypass}, 64'h7);
    chk("R8 bypass allowed with no locks (no error)", 64'(err_seen), 64'd0);
    rd(6'h20, rv);
    chk("R7 security readback", 64'(rv), 64'h7);
    wr(6'h20, 32'h00000000);
    rd(6'h20, rv);
    chk("R7 sticky bits stay, bypass clears", 64'(rv), 64'h3);
    wr(6'h00, 32'h84030681);
    chk("R5 lockdown mixed word", 64'(cfg_bytes[31:0]), 64'h00030081);
    chk("R10 error on lockdown drops", 64'(err_seen), 64'd1);
    wr(6'h00, 32'h00030001);
    chk("R5 lockdown ignores current lock", 64'(cfg_bytes[31:0]), 64'h00030001);
    chk("R10 no error on accepted lockdown word", 64'(err_seen), 64'd0);
    wr(6'h00, 32'h00000080);
    wr(6'h20, 32'h00000004);
    chk("R8 bypass masked while locked", 64'(mode_bypass), 64'd0);
    chk("R10 error on masked bypass", 64'(err_seen), 64'd1);
    rd(6'h20, rv);
    chk("R7 lockdown still set after writes", 64'(rv), 64'h3);
  endtask

  task automatic t_bypass();
    do_reset();
    wr(6'h20, 32'h00000004);
    chk("R8 bypass set with no locks", 64'(mode_bypass), 64'd1);
    wr(6'h00, 32'h00000080);
    wr(6'h00, 32'h00000001);
    chk("R4 bypass reopens locked entry", 64'(cfgb(0)), 64'h01);
    chk("R4 no error under bypass", 64'(err_seen), 64'd0);
    wr(6'h00, 32'h00000080);
    wr(6'h20, 32'h00000004);
    chk("R8 bypass kept when already set", 64'(mode_bypass), 64'd1);
    chk("R8 no error when bypass kept", 64'(err_seen), 64'd0);
    wr(6'h20, 32'h00000000);
    chk("R7 bypass clearable", 64'(mode_bypass), 64'd0);
    wr(6'h20, 32'h00000004);
    chk("R8 bypass masked after clear", 64'(mode_bypass), 64'd0);
    wr(6'h00, 32'h00000001);
    chk("R3 locked entry dropped without bypass", 64'(cfgb(0)), 64'h80);
    chk("R10 error on locked drop", 64'(err_seen), 64'd1);
  endtask

  initial begin
    t_reset();
    t_pack();
    t_rd_timing();
    t_lock();
    t_addr();
    t_range();
    t_lockdown();
    t_bypass();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule